// File: doc/BRIEF.md
# AAL5 Frame CRC Checker

This block sits on the receive side of a cell-based link. It accepts ATM cells as a stream of 32-bit words. Each cell is one header word, marked by a start-of-cell strobe, followed by a fixed number of payload words (twelve by default, which is 48 bytes). A frame occupies one or more consecutive cells. The sender pads the last cell so that the 64-bit trailer fills its final two words. The header of each cell says whether that cell closes the frame.

While a frame arrives, the block runs a CRC-32 over its payload. When the closing cell ends, it compares the CRC word carried in the trailer with its own result. It then raises a one-cycle completion pulse, with a pass/fail flag and the length field taken from the trailer. The CRC then starts afresh for the next frame. The block keeps one frame context only. It stores no payload, so the words must be copied elsewhere if they are needed.

The input is a valid/ready stream. A word is consumed on every rising edge where `in_valid` and `in_ready` are both high. Outside reset the block never applies back-pressure: `in_ready` is low only during reset and from the first edge after reset it stays high. The sender may insert idle cycles (`in_valid` low) anywhere in a cell. The status outputs are plain registered pins with no handshake.

Top module: `aal5_crc_checker`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `frame_done`, `crc_ok` and `frame_len` read zero at the first rising edge and after it.
- R2: A word is consumed only on an edge where both `in_valid` and `in_ready` are high. `in_ready` goes high on the first edge after reset and stays high. A word with `in_sop` high is a cell header, and the `PAYLOAD_WORDS` (12) payload words that follow it make up the cell body.
- R3: Bit 1 of the header word is the last-cell flag: 1 for the final cell of a frame and 0 otherwise. The PTI field occupies bits 3:1 and bit 1 is its least significant bit. No other header bit has any effect.
- R4: The CRC is the polynomial 0x04C11DB7 with the register preset to all ones. It is fed MSB first (bit 31 of each word first) with every payload word of the frame except the final word of the last cell. `crc_ok` is 1 exactly when that final word equals the bitwise complement of the CRC register. Outside a `frame_done` cycle, `crc_ok` is 0.
- R5: `frame_done` is high for exactly one cycle, namely the cycle that follows the edge that consumed the final payload word of a last cell.
- R6: `frame_len` takes bits 15:0 of the second-to-last payload word of the last cell and updates only when `frame_done` rises. It holds its value between frames. Bits 31:24 (user byte) and 23:16 (indicator byte) of that word are ignored.
- R7: The CRC register returns to all ones after every completed frame, so a failing frame has no effect on the result for the next frame.
- R8: A word without `in_sop` that arrives while no cell is open (before the first header, or after a cell body has ended) is ignored.
- R9: A header that arrives while a cell body is still open abandons the frame in progress. The CRC restarts and the new header opens a new cell.
- R10: Idle cycles inside a cell (`in_valid` low) change neither the CRC nor the word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block accepts a word (high except in reset) |
| in_sop | input | 1 | Current word is a cell header |
| in_data | input | 32 | Header or payload word |
| frame_done | output | 1 | One-cycle pulse when a frame ends |
| crc_ok | output | 1 | Trailer CRC matched (valid with `frame_done`) |
| frame_len | output | 16 | Length field of the last completed frame |

## Verification
The bound assertions check the following on every cycle: the completion pulse lasts exactly one cycle and only follows an accepted non-header word, `crc_ok` is never high without it, `frame_len` stays stable between pulses, and `in_ready` stays high once reset is released. The bench's scenarios are needed to show that the CRC value is correct and that frames split across several cells are handled. They also cover frames interleaved with idle gaps, corrupted trailers, stray words before any header, mid-cell aborts, and the fact that only header bit 1 picks the final cell. A behavioural model in the bench buffers each frame in a queue, computes the CRC byte by byte, and is compared with the outputs on every clock.

// File: rtl/aal5_chk_pkg.sv
package aal5_chk_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;

  typedef logic [WORD_W-1:0] word_t;

  // Per-word events decoded by the cell sequencer for the frame judge.
  typedef struct packed {
    logic body;      // accepted payload word of an open cell
    logic len_word;  // second-to-last word of a last cell
    logic crc_word;  // final word of a last cell (received CRC)
    logic abort;     // header arrived while a cell body was open
  } seq_ev_t;
endpackage

// File: rtl/aal5_crc_step.sv
module aal5_crc_step
  import aal5_chk_pkg::*;
#(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic [31:0] crc_in,
  input  word_t       data,
  output logic [31:0] crc_out
);
  // One shift stage per data bit, most significant bit first.
  logic [31:0] chain [WORD_W+1];

  assign chain[0] = crc_in;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][31] ^ data[WORD_W-1-i];
    assign chain[i+1] = {chain[i][30:0], 1'b0} ^ (fb ? POLY : 32'h0);
  end

  assign crc_out = chain[WORD_W];
endmodule

// File: rtl/aal5_cell_seq.sv
module aal5_cell_seq
  import aal5_chk_pkg::*;
#(
  parameter int PAYLOAD_WORDS = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    acc,
  input  logic    sop,
  input  logic    last_flag,
  output seq_ev_t ev
);
  localparam int IDX_W = (PAYLOAD_WORDS > 2) ? $clog2(PAYLOAD_WORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PAYLOAD_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_LEN = IDX_W'(PAYLOAD_WORDS - 2);

  logic             open_q;
  logic             last_q;
  logic [IDX_W-1:0] idx_q;
  logic             body;

  assign body        = acc && !sop && open_q;
  assign ev.body     = body;
  assign ev.abort    = acc && sop && open_q;
  assign ev.len_word = body && last_q && (idx_q == IDX_LEN);
  assign ev.crc_word = body && last_q && (idx_q == IDX_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      last_q <= 1'b0;
      idx_q  <= '0;
    end else if (acc && sop) begin
      open_q <= 1'b1;
      last_q <= last_flag;
      idx_q  <= '0;
    end else if (body) begin
      if (idx_q == IDX_END) begin
        open_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aal5_frame_judge.sv
module aal5_frame_judge
  import aal5_chk_pkg::*;
#(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_ev_t          ev,
  input  word_t            data,
  output logic             frame_done,
  output logic             crc_ok,
  output logic [LEN_W-1:0] frame_len
);
  logic [31:0]      crc_q;
  logic [31:0]      crc_nx;
  logic [LEN_W-1:0] len_cap_q;

  aal5_crc_step #(.POLY(POLY)) u_step (
    .crc_in (crc_q),
    .data   (data),
    .crc_out(crc_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q      <= '1;
      len_cap_q  <= '0;
      frame_done <= 1'b0;
      crc_ok     <= 1'b0;
      frame_len  <= '0;
    end else begin
      frame_done <= ev.crc_word;
      crc_ok     <= ev.crc_word && (data == ~crc_q);
      if (ev.abort || ev.crc_word) crc_q <= '1;
      else if (ev.body)            crc_q <= crc_nx;
      if (ev.len_word) len_cap_q <= data[LEN_W-1:0];
      if (ev.crc_word) frame_len <= len_cap_q;
    end
  end
endmodule

// File: rtl/aal5_crc_checker.sv
module aal5_crc_checker
  import aal5_chk_pkg::*;
#(
  parameter int          PAYLOAD_WORDS = 12,
  parameter int          LAST_BIT      = 1,
  parameter logic [31:0] POLY          = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sop,
  input  logic [31:0] in_data,
  output logic        frame_done,
  output logic        crc_ok,
  output logic [15:0] frame_len
);
  seq_ev_t ev;
  logic    acc;

  always_ff @(posedge clk) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign acc = in_valid && in_ready;

  aal5_cell_seq #(.PAYLOAD_WORDS(PAYLOAD_WORDS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .sop      (in_sop),
    .last_flag(in_data[LAST_BIT]),
    .ev       (ev)
  );

  aal5_frame_judge #(.POLY(POLY)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .data      (in_data),
    .frame_done(frame_done),
    .crc_ok    (crc_ok),
    .frame_len (frame_len)
  );
endmodule

// File: rtl/aal5_crc_checker_sva.sv
module aal5_crc_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_sop,
  input logic        frame_done,
  input logic        crc_ok,
  input logic [15:0] frame_len
);
  p_ready_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_done_after_body_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_valid && in_ready && !in_sop));

  p_ok_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> frame_done);

  p_len_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(frame_len));
endmodule

bind aal5_crc_checker aal5_crc_checker_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sop    (in_sop),
  .frame_done(frame_done),
  .crc_ok    (crc_ok),
  .frame_len (frame_len)
);

// File: tb/aal5_crc_checker_tb.sv
module aal5_crc_checker_tb;
  localparam int PW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        frame_done;
  logic        crc_ok;
  logic [15:0] frame_len;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int seed = 1;
  int done_seen = 0;
  logic last_ok = 1'b0;
  logic [15:0] last_len = '0;

  always #4 clk = ~clk;

  aal5_crc_checker u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .frame_done(frame_done),
    .crc_ok(crc_ok), .frame_len(frame_len)
  );

  // Byte-serial CRC over a word queue, most significant byte first.
  function automatic logic [31:0] crc_of(input logic [31:0] q[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (q[k]) begin
      for (int b = 3; b >= 0; b--) begin
        c = c ^ {q[k][b*8 +: 8], 24'h0};
        for (int t = 0; t < 8; t++)
          c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
      end
    end
    return c;
  endfunction

  // Reference model: frame words in a queue, result computed at frame end.
  logic [31:0] fq[$];
  bit   m_open = 0, m_last = 0, m_started = 0;
  int   m_cnt = 0;
  logic m_ready = 0, m_done = 0, m_ok = 0;
  logic [15:0] m_len = '0;

  always @(posedge clk) begin
    bit acc;
    acc = in_valid && m_ready;
    m_started = 1;
    m_done = 0;
    m_ok = 0;
    if (!rst_n) begin
      fq.delete(); m_open = 0; m_len = '0; m_cnt = 0;
    end else if (acc) begin
      if (in_sop) begin
        if (m_open) fq.delete();
        m_open = 1; m_cnt = 0; m_last = in_data[1];
      end else if (m_open) begin
        if (m_last && m_cnt == PW - 1) begin
          m_done = 1;
          m_len  = fq[fq.size()-1][15:0];
          m_ok   = (in_data == ~crc_of(fq));
          fq.delete();
          m_open = 0;
        end else begin
          fq.push_back(in_data);
          m_cnt++;
          if (m_cnt == PW) m_open = 0;
        end
      end
    end
    m_ready = rst_n;
  end

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_started) begin
      chk(in_ready === m_ready, rst_n ? "R2 in_ready" : "R1 in_ready", 32'(in_ready), 32'(m_ready));
      chk(frame_done === m_done, "R5 frame_done", 32'(frame_done), 32'(m_done));
      chk(crc_ok === m_ok, "R4 crc_ok", 32'(crc_ok), 32'(m_ok));
      chk(frame_len === m_len, "R6 frame_len", 32'(frame_len), 32'(m_len));
      if (frame_done === 1'b1) begin
        done_seen++; last_ok = crc_ok; last_len = frame_len;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [31:0] d, input logic s);
    @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_data = 32'hDEAD_BEEF;
    end
  endtask

  // Sends a frame of ncells cells; gap > 0 inserts an idle cycle every gap words.
  task automatic send_frame(input int ncells, input logic [15:0] len, input logic [15:0] uc,
                            input bit corrupt, input int gap, input logic [31:0] first_hdr);
    logic [31:0] pl[$];
    logic [31:0] c;
    int total = ncells * PW;
    for (int k = 0; k < total - 2; k++) begin
      pl.push_back(32'(k) * 32'h9E37_79B9 ^ 32'(seed) * 32'h0101_0003);
      seed++;
    end
    pl.push_back({uc, len});
    c = ~crc_of(pl);
    if (corrupt) c = c ^ 32'h0000_0100;
    pl.push_back(c);
    for (int cl = 0; cl < ncells; cl++) begin
      logic [31:0] h = {28'h000_050A, 2'b00, (cl == ncells - 1), 1'b0};
      if (cl == 0 && ncells > 1) h = first_hdr;
      put(h, 1'b1);
      for (int w = 0; w < PW; w++) begin
        put(pl[cl*PW + w], 1'b0);
        if (gap > 0 && (w % gap) == gap - 1) idle(1);
      end
    end
    idle(3);
  endtask

  initial begin
    int base;
    in_valid = 1'b1; in_data = 32'h2; in_sop = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b0 && frame_done === 1'b0 && crc_ok === 1'b0 && frame_len === 16'h0,
        "R1 reset state", {in_ready, frame_done, crc_ok, frame_len}, 32'h0);
    in_valid = 1'b0; in_sop = 1'b0;
    rst_n = 1'b1;
    idle(2);
    chk(in_ready === 1'b1, "R2 ready after reset", 32'(in_ready), 32'h1);

    // R8: stray words before any header
    put(32'h1234_5678, 1'b0); put(32'hFFFF_FFFF, 1'b0); idle(2);
    chk(done_seen == 0, "R8 stray words ignored", 32'(done_seen), 32'h0);

    // R4 R5: single-cell good frame
    send_frame(1, 16'd20, 16'h0000, 0, 0, '0);
    chk(done_seen == 1 && last_ok, "R4 single-cell good", {16'(done_seen), 15'h0, last_ok}, {16'h1, 16'h1});
    chk(last_len == 16'd20, "R6 length single", 32'(last_len), 32'd20);

    // R3 R10: three cells with idle gaps; first header has every bit except bit 1 set
    send_frame(3, 16'd100, 16'h0000, 0, 4, 32'hFFFF_FFFD);
    chk(done_seen == 2 && last_ok, "R3 R10 multi-cell gaps", {16'(done_seen), 15'h0, last_ok}, {16'h2, 16'h1});

    // R4: corrupted CRC
    send_frame(2, 16'd60, 16'h0000, 1, 0, 32'h0000_0000);
    chk(done_seen == 3 && !last_ok, "R4 bad CRC flagged", {16'(done_seen), 15'h0, last_ok}, {16'h3, 16'h0});

    // R7: good frame right after a failing one
    send_frame(1, 16'd8, 16'h0000, 0, 0, '0);
    chk(done_seen == 4 && last_ok, "R7 recovery after bad", {16'(done_seen), 15'h0, last_ok}, {16'h4, 16'h1});

    // R6: user and indicator bytes set, maximum length
    send_frame(1, 16'hFFFF, 16'hA55A, 0, 0, '0);
    chk(last_ok && last_len == 16'hFFFF, "R6 upper bytes ignored", {15'h0, last_ok, last_len}, {16'h1, 16'hFFFF});

    // R3: non-last cell alone completes nothing
    base = done_seen;
    put(32'h0000_0000, 1'b1);
    for (int w = 0; w < PW; w++) put(32'h0F0F_0000 + 32'(w), 1'b0);
    idle(3);
    chk(done_seen == base, "R3 non-last cell no done", 32'(done_seen), 32'(base));
    // R8: words after cell end, outside any cell
    put(32'hCAFE_0001, 1'b0); put(32'hCAFE_0002, 1'b0); idle(2);
    chk(done_seen == base, "R8 words after cell ignored", 32'(done_seen), 32'(base));

    // R9: abandoned partial last cell, then a clean frame
    put(32'h0000_0002, 1'b1);
    for (int w = 0; w < 5; w++) put(32'h7777_0000 + 32'(w), 1'b0);
    send_frame(1, 16'd33, 16'h0000, 0, 0, '0);
    chk(done_seen == base + 1 && last_ok && last_len == 16'd33, "R9 abort then good",
        {16'(done_seen - base), 15'h0, last_ok}, {16'h1, 16'h1});

    // R10: long gaps, back-to-back frames
    send_frame(2, 16'd77, 16'h0000, 0, 1, 32'h0000_0000);
    send_frame(1, 16'd5, 16'h0000, 0, 0, '0);
    chk(done_seen == base + 3 && last_ok && last_len == 16'd5, "R10 R7 back-to-back",
        {16'(done_seen - base), 15'h0, last_ok}, {16'h3, 16'h1});

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule